// File: doc/BRIEF.md
# Masked-Pin Serial Byte Shifter

This block sends bytes one bit at a time on two pins of a general-purpose output port. A configuration word chooses which port pins act as the serial clock and which carry the serial data, and it also sets the bit order. A configuration is taken only if both pin masks reach pins that the port lets this block change and that are currently enabled as outputs. If the check fails, both masks are cleared.

Bytes arrive through a valid/ready handshake. For each bit the block drives the clock pins low, then drives the data pins to the bit value, then raises the clock. Each of these three phases lasts `PHASE_CYC` clock cycles, so the data is held for at least one full phase before the clock rises. Port bits outside the two masks pass straight from `port_in` to `port_out`. The block's own bits override only the masked positions.

FSM states: `ST_IDLE` (ready, clock pins high), `ST_CLK_LO` (clock driven low), `ST_DATA` (data pins take the bit value, clock still low), `ST_CLK_HI` (clock high, data held). Transitions:
- `ST_IDLE` to `ST_CLK_LO` when a byte is accepted with both masks non-zero.
- `ST_CLK_LO` to `ST_DATA` at the end of a phase.
- `ST_DATA` to `ST_CLK_HI` at the end of a phase.
- `ST_CLK_HI` to `ST_CLK_LO` at the end of a phase when bits remain.
- `ST_CLK_HI` to `ST_IDLE` at the end of the phase of the eighth bit.

Top module: `serial_byte_shifter`

## Requirements
- R1: The configuration word uses bits [7:0] as the clock-pin mask, bits [15:8] as the data-pin mask and bit 16 as the order flag (1 = most significant bit first). Mask bit i selects port bit i.
- R2: A configuration presented while idle is accepted when each mask shares at least one set bit with `chg_mask[7:0]` and at least one set bit with `oe_bits[7:0]`. On acceptance `cfg_ok` pulses in the next cycle, and the new masks and order take effect in that same cycle.
- R3: A configuration presented while idle that fails the check of R2 raises `cfg_rej` in the next cycle and clears both masks. `port_out` then equals `port_in`.
- R4: A configuration presented while a byte is shifting is ignored. No `cfg_ok` or `cfg_rej` pulse appears, and the masks and order stay unchanged.
- R5: `in_ready` is high when idle. A byte is accepted at a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from the next cycle until the byte ends.
- R6: A byte presented while either mask is zero is consumed with `wr_err` high in the handshake cycle. No pin changes and `in_ready` stays high.
- R7: Each bit consists of three phases of `PHASE_CYC` cycles each: clock pins low, then data pins at the bit value with the clock still low, then clock pins high. The data pins are therefore stable for at least `PHASE_CYC` cycles before each clock rise.
- R8: The eight bits go out from bit 7 down to bit 0 when the order flag is 1, and from bit 0 up to bit 7 otherwise.
- R9: `done` is high for exactly one cycle: the last cycle of the clock-high phase of the eighth bit, which is cycle 24*`PHASE_CYC` counted from the cycle after the handshake. `in_ready` is high in the following cycle.
- R10: Port bits outside both masks, including all bits at index 8 and above, equal `port_in`. A bit set in both masks follows the clock level.
- R11: Between bytes the clock pins stay high and the data pins keep the last bit sent.
- R12: After reset, both masks are zero, `in_ready` is 1, `cfg_ok`, `cfg_rej`, `done` and `wr_err` are 0, and `port_out` equals `port_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_word | input | 17 | Clock mask, data mask and order flag |
| chg_mask | input | PORT_W | Port bits this block may change |
| oe_bits | input | PORT_W | Current output-enable bits of the port |
| cfg_ok | output | 1 | Configuration accepted pulse |
| cfg_rej | output | 1 | Configuration rejected pulse |
| in_valid | input | 1 | Byte available |
| in_byte | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| wr_err | output | 1 | Byte refused because no valid configuration is loaded |
| done | output | 1 | Last cycle of a byte |
| port_in | input | PORT_W | Port value from the rest of the port logic |
| port_out | output | PORT_W | Port value with the clock and data pins merged in |

## Verification
A bit index that is off by one, or a wrong order flag, shows as a wrong reconstructed byte at the `done` pulse of the same byte. A phase counter that is off shows as a `done` that arrives in the wrong cycle, or as a data pin that changes fewer than `PHASE_CYC` cycles before a clock rise, and this is detected at the first clock rise. A mask register left in a wrong state shows within one cycle: either as an unmasked `port_out` bit that differs from `port_in`, or as a wrong `cfg_ok`/`cfg_rej` response.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int MASK_W = 8;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int CFG_W  = 2 * MASK_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLK_LO = 2'd1,
        ST_DATA   = 2'd2,
        ST_CLK_HI = 2'd3
    } sbs_state_e;

    // packed layout matches the configuration word: order flag on top
    typedef struct packed {
        logic              msb_first;
        logic [MASK_W-1:0] dat_mask;
        logic [MASK_W-1:0] clk_mask;
    } sbs_cfg_t;
endpackage

// File: rtl/sbs_cfg_reg.sv
module sbs_cfg_reg
    import sbs_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cfg_en,
    input  logic [PORT_W-1:0] chg_mask,
    input  logic [PORT_W-1:0] oe_bits,
    output sbs_cfg_t          cfg_q,
    output logic              armed,
    output logic              cfg_ok,
    output logic              cfg_rej
);
    sbs_cfg_t          cand;
    logic [MASK_W-1:0] chg_lo;
    logic [MASK_W-1:0] oe_lo;
    logic              pass;

    always_comb begin
        cand   = sbs_cfg_t'(cfg_word);
        chg_lo = chg_mask[MASK_W-1:0];
        oe_lo  = oe_bits[MASK_W-1:0];
        pass   = (|(cand.clk_mask & chg_lo)) && (|(cand.dat_mask & chg_lo))
              && (|(cand.clk_mask & oe_lo))  && (|(cand.dat_mask & oe_lo));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cfg_ok  <= 1'b0;
            cfg_rej <= 1'b0;
        end else begin
            cfg_ok  <= 1'b0;
            cfg_rej <= 1'b0;
            if (cfg_valid && cfg_en) begin
                if (pass) begin
                    cfg_q  <= cand;
                    cfg_ok <= 1'b1;
                end else begin
                    cfg_q.clk_mask <= '0;
                    cfg_q.dat_mask <= '0;
                    cfg_rej        <= 1'b1;
                end
            end
        end
    end

    assign armed = (|cfg_q.clk_mask) && (|cfg_q.dat_mask);

    a_r3_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rej |-> (cfg_q.clk_mask == '0 && cfg_q.dat_mask == '0));
    a_r2_accept_arms: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> armed);
    a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ok && cfg_rej));
    a_r4_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!cfg_ok && !cfg_rej && $stable(cfg_q)));
endmodule

// File: rtl/sbs_phase_timer.sv
module sbs_phase_timer #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = !hold && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || hold || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    initial begin
        a_r7_phase_min: assert (PHASE_CYC >= 1);
    end
endmodule

// File: rtl/sbs_bit_seq.sv
module sbs_bit_seq
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              armed,
    input  logic              msb_first,
    input  logic              tick,
    output logic              in_ready,
    output logic              wr_err,
    output logic              done,
    output logic              clk_lvl,
    output logic              dat_lvl,
    output logic              timer_hold
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    sbs_state_e        st;
    sbs_state_e        st_nx;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] sh;
    logic              cur_bit;
    logic              last_bit;
    logic              take;

    assign take     = (st == ST_IDLE) && in_valid && armed;
    assign last_bit = (idx == LAST_IDX);
    assign cur_bit  = msb_first ? sh[LAST_IDX - idx] : sh[idx];

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (take) st_nx = ST_CLK_LO;
            ST_CLK_LO: if (tick) st_nx = ST_DATA;
            ST_DATA:   if (tick) st_nx = ST_CLK_HI;
            ST_CLK_HI: if (tick) st_nx = last_bit ? ST_IDLE : ST_CLK_LO;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            sh      <= '0;
            dat_lvl <= 1'b0;
        end else begin
            st <= st_nx;
            if (take) begin
                sh  <= in_byte;
                idx <= '0;
            end
            if (st == ST_CLK_LO && tick) begin
                dat_lvl <= cur_bit;
            end
            if (st == ST_CLK_HI && tick && !last_bit) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        in_ready   = (st == ST_IDLE);
        timer_hold = (st == ST_IDLE);
        wr_err     = (st == ST_IDLE) && in_valid && !armed;
        clk_lvl    = !(st == ST_CLK_LO || st == ST_DATA);
        done       = (st == ST_CLK_HI) && tick && last_bit;
    end

    a_r7_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lvl) |-> $stable(dat_lvl));
    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);
    a_r5_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && armed) |=> !in_ready);
    a_r6_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> (in_ready && $stable(dat_lvl)));
    a_r11_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> clk_lvl);
endmodule

// File: rtl/sbs_port_merge.sv
module sbs_port_merge
    import sbs_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic [PORT_W-1:0] port_in,
    input  logic [MASK_W-1:0] clk_mask,
    input  logic [MASK_W-1:0] dat_mask,
    input  logic              clk_lvl,
    input  logic              dat_lvl,
    output logic [PORT_W-1:0] port_out
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i < MASK_W) begin : g_owned
            assign port_out[i] = clk_mask[i] ? clk_lvl
                               : (dat_mask[i] ? dat_lvl : port_in[i]);
        end else begin : g_pass
            assign port_out[i] = port_in[i];
        end
    end
endmodule

// File: rtl/serial_byte_shifter.sv
module serial_byte_shifter
    import sbs_pkg::*;
#(
    parameter int PORT_W    = 16,
    parameter int PHASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [PORT_W-1:0] chg_mask,
    input  logic [PORT_W-1:0] oe_bits,
    output logic              cfg_ok,
    output logic              cfg_rej,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              wr_err,
    output logic              done,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] port_out
);
    sbs_cfg_t cfg_q;
    logic     armed;
    logic     tick;
    logic     timer_hold;
    logic     clk_lvl;
    logic     dat_lvl;

    sbs_cfg_reg #(.PORT_W(PORT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .cfg_en(in_ready), .chg_mask(chg_mask), .oe_bits(oe_bits),
        .cfg_q(cfg_q), .armed(armed), .cfg_ok(cfg_ok), .cfg_rej(cfg_rej)
    );

    sbs_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .hold(timer_hold), .tick(tick)
    );

    sbs_bit_seq u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .armed(armed), .msb_first(cfg_q.msb_first), .tick(tick),
        .in_ready(in_ready), .wr_err(wr_err), .done(done),
        .clk_lvl(clk_lvl), .dat_lvl(dat_lvl), .timer_hold(timer_hold)
    );

    sbs_port_merge #(.PORT_W(PORT_W)) u_merge (
        .port_in(port_in), .clk_mask(cfg_q.clk_mask), .dat_mask(cfg_q.dat_mask),
        .clk_lvl(clk_lvl), .dat_lvl(dat_lvl), .port_out(port_out)
    );
endmodule

// File: tb/serial_byte_shifter_tb_top.sv
module serial_byte_shifter_tb_top;
    localparam int PW = 12;
    localparam int PH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [16:0]   cfg_word = '0;
    logic [PW-1:0] chg_mask = '0;
    logic [PW-1:0] oe_bits = '0;
    logic          cfg_ok, cfg_rej;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          in_ready, wr_err, done;
    logic [PW-1:0] port_in = '0;
    logic [PW-1:0] port_out;

    int total = 0;
    int bad = 0;
    logic [7:0] cm = '0;
    logic [7:0] dm = '0;
    int cpi = 0;
    int dpi = 0;
    bit mon_on = 1'b0;
    bit prev_c = 1'b1;
    bit prev_d = 1'b0;
    int stab = 0;
    int ncap = 0;
    bit cap [8];

    always #2 clk = ~clk;

    serial_byte_shifter #(.PORT_W(PW), .PHASE_CYC(PH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .chg_mask(chg_mask), .oe_bits(oe_bits), .cfg_ok(cfg_ok), .cfg_rej(cfg_rej),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .wr_err(wr_err), .done(done), .port_in(port_in), .port_out(port_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit cfg_pass(input logic [7:0] c, input logic [7:0] d,
                                    input logic [7:0] chg, input logic [7:0] oe);
        return (|(c & chg)) && (|(d & chg)) && (|(c & oe)) && (|(d & oe));
    endfunction

    function automatic int low_bit(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] rebuild(input bit msb);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            if (msb) r[7-i] = cap[i];
            else     r[i]   = cap[i];
        end
        return r;
    endfunction

    // pin monitor: R10 pass-through, R7 setup, capture at clock rises
    always @(negedge clk) begin
        if (rst_n) begin
            logic [PW-1:0] own;
            bit cur_c, cur_d;
            own = '0;
            own[7:0] = cm | dm;
            chk((port_out & ~own) == (port_in & ~own), "R10 unmasked bits follow port_in",
                32'(port_out), 32'(port_in));
            cur_c = port_out[cpi];
            cur_d = port_out[dpi];
            if (cm != 0)
                chk((port_out[7:0] & cm) == (cur_c ? cm : 8'h00), "R10 clock pins agree",
                    32'(port_out[7:0] & cm), 32'(cur_c ? cm : 8'h00));
            if (cur_d == prev_d) stab++;
            else stab = 0;
            if (mon_on && cur_c && !prev_c) begin
                chk(stab >= PH, "R7 data setup before clock rise", stab, PH);
                if (ncap < 8) cap[ncap] = cur_d;
                ncap++;
            end
            prev_c = cur_c;
            prev_d = cur_d;
        end
    end

    task automatic do_cfg(input logic [7:0] c, input logic [7:0] d, input bit m,
                          input logic [7:0] chg, input logic [7:0] oe);
        bit ok;
        ok = cfg_pass(c, d, chg, oe);
        @(negedge clk);
        chg_mask = {PW{1'b0}} | {4'($urandom), chg};
        oe_bits  = {PW{1'b0}} | {4'($urandom), oe};
        cfg_word = {m, d, c};
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        if (ok) begin
            chk(cfg_ok && !cfg_rej, "R2 accepted config pulses cfg_ok", {cfg_ok, cfg_rej}, 2'b10);
            cm = c;
            dm = d;
            cpi = low_bit(c);
            dpi = ((d & ~c) != 0) ? low_bit(d & ~c) : cpi;
        end else begin
            chk(!cfg_ok && cfg_rej, "R3 rejected config pulses cfg_rej", {cfg_ok, cfg_rej}, 2'b01);
            cm = '0;
            dm = '0;
            cpi = 0;
            dpi = 0;
            #1;
            chk(port_out == port_in, "R3 masks cleared after reject", 32'(port_out), 32'(port_in));
        end
    endtask

    task automatic send(input logic [7:0] b, input bit msb, input bit poke);
        int n;
        bit rdy_ok;
        @(negedge clk);
        port_in = PW'($urandom);
        in_byte = b;
        in_valid = 1'b1;
        ncap = 0;
        mon_on = 1'b1;
        #1;
        chk(in_ready && !wr_err, "R5 ready while idle", {in_ready, wr_err}, 2'b10);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        n = 0;
        rdy_ok = 1'b1;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (poke && n == 5) begin
                cfg_word = {~msb, 8'h0C, 8'h30};
                cfg_valid = 1'b1;
            end
            if (poke && n == 6) begin
                chk(!cfg_ok && !cfg_rej, "R4 config while busy has no answer",
                    {cfg_ok, cfg_rej}, 2'b00);
                cfg_valid = 1'b0;
            end
            if (done) break;
            if (in_ready) rdy_ok = 1'b0;
        end
        chk(n == 24 * PH, "R9 done in last high-phase cycle", n, 24 * PH);
        chk(rdy_ok, "R5 ready low while shifting", rdy_ok, 1);
        @(negedge clk);
        chk(in_ready, "R9 ready after done", in_ready, 1);
        chk(port_out[cpi] == 1'b1, "R11 clock idles high", port_out[cpi], 1);
        chk(port_out[dpi] == cap[7], "R11 data holds last bit", port_out[dpi], cap[7]);
        mon_on = 1'b0;
        chk(ncap == 8, "R7 eight clock rises per byte", ncap, 8);
        chk(rebuild(msb) == b, msb ? "R8 MSB-first byte" : "R8 LSB-first byte",
            rebuild(msb), b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        port_in = PW'($urandom);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(in_ready && !cfg_ok && !cfg_rej && !done && !wr_err, "R12 reset outputs",
            {in_ready, cfg_ok, cfg_rej, done, wr_err}, 5'b10000);
        chk(port_out == port_in, "R12 port passes through", 32'(port_out), 32'(port_in));

        // R6 write without configuration
        @(negedge clk);
        in_byte = 8'h5A;
        in_valid = 1'b1;
        #1;
        chk(wr_err && in_ready, "R6 refused write flags wr_err", {wr_err, in_ready}, 2'b11);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk(in_ready && port_out == port_in, "R6 no pin activity",
            32'(port_out), 32'(port_in));

        // R3 rejections: clock pin not changeable, data pin not an output
        do_cfg(8'h01, 8'h02, 1'b1, 8'hFE, 8'hFF);
        do_cfg(8'h01, 8'h02, 1'b1, 8'hFF, 8'h01);

        // R1/R2 accept, then directed bytes
        do_cfg(8'h01, 8'h02, 1'b1, 8'hFF, 8'hFF);
        @(negedge clk);
        chk(port_out[0] == 1'b1, "R11 clock pin high after config", port_out[0], 1);
        send(8'hA5, 1'b1, 1'b0);
        send(8'h01, 1'b1, 1'b0);
        send(8'h80, 1'b1, 1'b1);   // R4 poke while busy
        send(8'h3C, 1'b1, 1'b0);   // order must still be MSB-first

        // R1 order flag low, multi-bit masks
        do_cfg(8'h30, 8'h0C, 1'b0, 8'h3C, 8'h3C);
        send(8'h01, 1'b0, 1'b0);
        send(8'hC6, 1'b0, 1'b0);

        // R10 overlap: bit 1 in both masks follows the clock
        do_cfg(8'h03, 8'h02, 1'b1, 8'hFF, 8'hFF);
        @(negedge clk);
        chk(port_out[1] == 1'b1, "R10 overlapping bit follows clock", port_out[1], 1);

        // clear again and confirm refusal
        do_cfg(8'h00, 8'h02, 1'b1, 8'hFF, 8'hFF);
        @(negedge clk);
        in_valid = 1'b1;
        #1;
        chk(wr_err, "R6 refused after reject", wr_err, 1);
        @(posedge clk);
        #1 in_valid = 1'b0;

        // random mix
        for (int it = 0; it < 30; it++) begin
            int ci;
            logic [7:0] c, d, chg, oe;
            bit m;
            ci = $urandom % 8;
            c = 8'(1 << ci);
            d = 8'(1 << ((ci + 1 + ($urandom % 7)) % 8));
            chg = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
            oe  = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
            m = 1'($urandom);
            do_cfg(c, d, m, chg, oe);
            if (cfg_pass(c, d, chg, oe)) begin
                send(8'($urandom), m, 1'b0);
                send(8'($urandom), m, 1'b0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule